// File: doc/BRIEF.md
# Instruction TLB Four-Way Recency Tracker

This block keeps the replacement order of a four-entry instruction translation buffer. The order is held as a six-bit pairwise-comparison field. Software can read and write this field as part of the MMU control register. Each time an entry is used, either on a lookup hit or on a refill, the block pulses a use strobe with that entry's index, and the field is updated in the next cycle. The TLB contents, the lookup compare and the refill datapath are outside this block.

The victim for the next refill is decoded combinationally from the registered field. Four patterns are tried in a fixed priority order. A refill written into the reported victim is signalled as an ordinary use of that index, so the order is refreshed with no separate path. A field value that matches none of the four patterns is reported on an error flag, and the victim then falls back to entry 0.

Top module: `itlb_lru_tracker`

## Requirements
- R1: While reset is asserted, and immediately after it, the field equals the parameter RST_STATE (default 6'h00). With the default, the victim is 3 and the illegal flag is 0.
- R2: A use of entry 0 clears field bits [5:3] and keeps bits [2:0] unchanged.
- R3: A use of entry 1 sets field bit 5, clears bits [2:1] and keeps bits 4, 3 and 0.
- R4: A use of entry 2 sets field bits 4 and 2, clears bit 0 and keeps bits 5, 3 and 1.
- R5: A use of entry 3 sets field bits 3, 1 and 0 and keeps bits 5, 4 and 2.
- R6: The victim is chosen by the first rule that matches, in this order:
  - entry 0 if bits [5:3] are 111;
  - entry 1 if bit 5 is 0 and bits 2 and 1 are 1;
  - entry 2 if bits 4 and 2 are 0 and bit 0 is 1;
  - entry 3 if bits 3, 1 and 0 are 0.
- R7: A field that matches no rule (for example 6'h05) drives illegal_o high and victim_o to 0. Every matching field drives illegal_o low.
- R8: A software write loads wr_data into the field in the next cycle. It takes precedence over a use in the same cycle.
- R9: With neither a use nor a write, the field holds its value, whatever use_idx is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_vld | input | 1 | An entry was hit or refilled this cycle |
| use_idx | input | 2 | Index of the entry used |
| wr_en | input | 1 | Software write of the recency field |
| wr_data | input | 6 | Value to write |
| state_o | output | 6 | Current recency field (control register bits [31:26]) |
| victim_o | output | 2 | Entry to replace on the next refill |
| illegal_o | output | 1 | Field matches no victim pattern |

## Verification
The bench builds the block with its default parameters: a two-bit index, a six-bit field and a reset value of zero. With these, a use chain starting from reset reaches every victim rule, including the case where all field bits are set, which the entry-0 rule wins. Software writes then place the field in states that no use sequence can reach, such as 6'h05. These exercise the illegal fallback and the write-over-use precedence.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
    localparam int IDX_W   = 2;
    localparam int NENT    = 1 << IDX_W;
    localparam int STATE_W = 6;

    typedef logic [STATE_W-1:0] lru_t;
    typedef logic [IDX_W-1:0]   idx_t;

    // bits forced to one when an entry is used
    function automatic lru_t set_mask(input idx_t e);
        case (e)
            2'd0:    set_mask = 6'b000000;
            2'd1:    set_mask = 6'b100000;
            2'd2:    set_mask = 6'b010100;
            default: set_mask = 6'b001011;
        endcase
    endfunction

    // bits forced to zero when an entry is used
    function automatic lru_t clr_mask(input idx_t e);
        case (e)
            2'd0:    clr_mask = 6'b111000;
            2'd1:    clr_mask = 6'b000110;
            2'd2:    clr_mask = 6'b000001;
            default: clr_mask = 6'b000000;
        endcase
    endfunction

    // bits an entry's victim pattern looks at
    function automatic lru_t care_mask(input idx_t e);
        care_mask = set_mask(e) | clr_mask(e);
    endfunction

    // the pattern value that marks an entry as oldest: the opposite of a use
    function automatic lru_t old_value(input idx_t e);
        old_value = clr_mask(e);
    endfunction
endpackage

// File: rtl/itlb_lru_update.sv
module itlb_lru_update
    import itlb_lru_pkg::*;
(
    input  lru_t cur,
    input  idx_t idx,
    output lru_t nxt
);
    always_comb begin
        nxt = (cur & ~clr_mask(idx)) | set_mask(idx);
    end
endmodule

// File: rtl/itlb_lru_victim.sv
module itlb_lru_victim
    import itlb_lru_pkg::*;
(
    input  lru_t cur,
    output idx_t victim,
    output logic illegal
);
    logic [NENT-1:0] hit;

    for (genvar g = 0; g < NENT; g++) begin : g_pat
        assign hit[g] = ((cur & care_mask(idx_t'(g))) == old_value(idx_t'(g)));
    end

    always_comb begin
        victim  = '0;
        illegal = 1'b1;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                victim  = idx_t'(i);
                illegal = 1'b0;
            end
        end
    end
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
    import itlb_lru_pkg::*;
#(
    parameter logic [5:0] RST_STATE = 6'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_vld,
    input  logic [1:0] use_idx,
    input  logic       wr_en,
    input  logic [5:0] wr_data,
    output logic [5:0] state_o,
    output logic [1:0] victim_o,
    output logic       illegal_o
);
    typedef struct packed {
        lru_t lru;
    } regs_t;

    regs_t r_d, r_q;
    lru_t  upd;

    itlb_lru_update u_upd (
        .cur (r_q.lru),
        .idx (use_idx),
        .nxt (upd)
    );

    itlb_lru_victim u_vic (
        .cur     (r_q.lru),
        .victim  (victim_o),
        .illegal (illegal_o)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en)        r_d.lru = wr_data;
        else if (use_vld) r_d.lru = upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.lru <= RST_STATE;
        else        r_q     <= r_d;
    end

    assign state_o = r_q.lru;
endmodule

// File: rtl/itlb_lru_tracker_chk.sv
module itlb_lru_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       use_vld,
    input logic [1:0] use_idx,
    input logic       wr_en,
    input logic [5:0] wr_data,
    input logic [5:0] state_o,
    input logic [1:0] victim_o,
    input logic       illegal_o
);
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_o == $past(wr_data)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !use_vld) |=> $stable(state_o)); // R9
    AST_USE0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_vld && !wr_en && use_idx == 2'd0) |=>
        (state_o[5:3] == 3'b000 && state_o[2:0] == $past(state_o[2:0]))); // R2
    AST_USE3_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_vld && !wr_en && use_idx == 2'd3) |=>
        (state_o[3] && state_o[1] && state_o[0])); // R5
    AST_ILLEGAL_VICTIM0: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> victim_o == 2'd0); // R7
    AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o[5:3] == 3'b111) |-> (victim_o == 2'd0 && !illegal_o)); // R6
endmodule

bind itlb_lru_tracker itlb_lru_tracker_chk u_chk (.*);

// File: tb/itlb_lru_tracker_test.sv
module itlb_lru_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {use index, expected field, expected victim}
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd3, 6'h0B, 2'd2},
        {2'd2, 6'h1E, 2'd1},
        {2'd1, 6'h38, 2'd0},
        {2'd0, 6'h00, 2'd3},
        {2'd1, 6'h20, 2'd3},
        {2'd2, 6'h34, 2'd3},
        {2'd3, 6'h3F, 2'd0},
        {2'd0, 6'h07, 2'd1}
    };

    logic clk = 0, rst_n = 0, use_vld = 0, wr_en = 0;
    logic [1:0] use_idx = 0;
    logic [5:0] wr_data = 0;
    logic [5:0] state_o;
    logic [1:0] victim_o;
    logic illegal_o;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    itlb_lru_tracker uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 state", state_o, 6'h00);
        chk("R1 victim", victim_o, 3);
        chk("R1 illegal", illegal_o, 0);
        @(negedge clk) rst_n = 1;
        // R2 R3 R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk); use_vld = 1; use_idx = VEC[i][9:8];
            step();
            chk("R2-5 use state", state_o, VEC[i][7:2]);
            chk("R6 victim", victim_o, VEC[i][1:0]);
            chk("R7 legal", illegal_o, 0);
        end
        // R9 idle holds with changing index
        @(negedge clk); use_vld = 0; use_idx = 2'd0;
        step(); step();
        chk("R9 hold", state_o, 6'h07);
        // R7 illegal via write, R8 load
        @(negedge clk); wr_en = 1; wr_data = 6'h05;
        step();
        chk("R8 write", state_o, 6'h05);
        chk("R7 illegal flag", illegal_o, 1);
        chk("R7 fallback victim", victim_o, 0);
        // R8 write beats use
        @(negedge clk); wr_data = 6'h38; use_vld = 1; use_idx = 2'd0;
        step();
        chk("R8 precedence", state_o, 6'h38);
        chk("R6 oldest 0", victim_o, 0);
        // R2 keeps low bits from a written state
        @(negedge clk); wr_en = 0; use_idx = 2'd0;
        @(negedge clk); wr_en = 1; wr_data = 6'h3D; use_vld = 0;
        @(negedge clk); wr_en = 0; use_vld = 1; use_idx = 2'd0;
        step();
        chk("R2 keep low", state_o, 6'h05);
        // R1 reset mid-run
        @(negedge clk); use_vld = 0; rst_n = 0;
        step();
        chk("R1 reset again", state_o, 6'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule